// File: doc/BRIEF.md
# Zone resource admission counter

This block decides whether a zone-open request on a zoned storage namespace may go ahead. It keeps three pools: a count of zones in use as active, a count of zones in use as open, and a count of free random-write-area buffers. A request states how many active and open slots it needs and whether it wants a buffer. The block answers one cycle later with a 16-bit status and an attribute byte, and it charges the pools only when it grants the request. Release strobes return resources when a zone is finished or reset.

The limits and the buffer count are captured from configuration inputs while reset is held. A limit of zero disables that check. A buffer count of zero gives one buffer per zone. Only one event is taken per cycle. A release always goes first, and while a release is present the request side is held off.

Top module: `zone_admit`

## Requirements
- R1: While `rst` is high the configuration inputs are captured. After reset `resp_valid` and `err` are 0, `req_ready` is 1, nothing is in use, and the free-buffer pool is full.
- R2: A maximum-active or maximum-open value of 0 disables that limit, so any number of slots may be granted against it.
- R3: A request whose active need, added to the active count in use, exceeds a non-zero maximum-active value is refused with status 0x41BD. This is the code 0x1BD with the do-not-retry bit 14 set. No pool changes.
- R4: A request whose open need, added to the open count in use, exceeds a non-zero maximum-open value is refused with status 0x41BE. No pool changes.
- R5: A buffer request made when no buffer is free is refused with status 0x41B7. No pool changes.
- R6: The checks run in a fixed order: active first, then open, then buffer. The first failing check decides the status.
- R7: A granted request returns status 0x0000 and adds its needs to the active and open counts. If it asked for a buffer, it takes one buffer and sets `resp_attr` bit 3. Otherwise `resp_attr` is 0x00, and it is also 0x00 on every refusal.
- R8: A release with `rel_act`, `rel_opn` or `rel_buf` set returns one active slot, one open slot or one buffer.
- R9: A configured buffer count of 0 makes the pool `ZONES` buffers deep.
- R10: `cfg_err` is 1 when the configured buffer count exceeds a non-zero maximum-active value, and 0 otherwise.
- R11: A release of a resource that is not held raises `err` for one cycle, in the cycle after the release. The counters never go below zero, and the free pool never rises above its size.
- R12: `req_ready` is 0 in any cycle with `rel_valid` high. The release is applied first, and the waiting request is taken on a later cycle against the updated counts.
- R13: `resp_valid` pulses for one cycle, in the cycle after each accepted request, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; configuration is captured while high |
| cfg_max_active | input | CNT_W | Maximum active zones, 0 = unlimited |
| cfg_max_open | input | CNT_W | Maximum open zones, 0 = unlimited |
| cfg_num_buf | input | CNT_W | Number of buffers, 0 = one per zone |
| cfg_err | output | 1 | Captured configuration is inconsistent |
| req_valid | input | 1 | Open request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_act | input | AMT_W | Active slots needed |
| req_opn | input | AMT_W | Open slots needed |
| req_buf | input | 1 | Buffer wanted |
| rel_valid | input | 1 | Release present |
| rel_act | input | 1 | Return one active slot |
| rel_opn | input | 1 | Return one open slot |
| rel_buf | input | 1 | Return one buffer |
| resp_valid | output | 1 | Response to the request accepted last cycle |
| resp_status | output | 16 | Status code |
| resp_attr | output | 8 | Zone attribute byte, bit 3 = buffer held |
| err | output | 1 | Unmatched release in the previous cycle |

## Verification
The counters cannot be read at the ports, so a wrong count shows up only as a wrong decision. A count left too high turns a later grant into one of the refusal codes. A count left too low lets through a request that should have been refused. A counter that wraps below zero refuses the very next request against that limit. For this reason each release in the bench is followed by requests aimed exactly at the limit, so that a counter off by one, or a pool that fills past its size, shows up within one or two responses.

// File: rtl/zone_admit_pkg.sv
package zone_admit_pkg;

    localparam logic [15:0] ST_OK      = 16'h0000;
    localparam logic [15:0] ST_NO_RTRY = 16'h4000;
    localparam logic [15:0] ST_ACT     = ST_NO_RTRY | 16'h01BD;
    localparam logic [15:0] ST_OPN     = ST_NO_RTRY | 16'h01BE;
    localparam logic [15:0] ST_BUF     = ST_NO_RTRY | 16'h01B7;
    localparam int          ATTR_BUF   = 3;
    localparam int          NPOOL      = 3;

    typedef struct packed {
        logic        valid;
        logic [15:0] status;
        logic [7:0]  attr;
        logic        err;
    } resp_t;

endpackage

// File: rtl/zone_admit_check.sv
module zone_admit_check #(
    parameter int CNT_W = 5,
    parameter int AMT_W = 2
) (
    input  logic [CNT_W-1:0] act_used,
    input  logic [CNT_W-1:0] opn_used,
    input  logic [CNT_W-1:0] buf_free,
    input  logic [CNT_W-1:0] max_act,
    input  logic [CNT_W-1:0] max_opn,
    input  logic [AMT_W-1:0] need_act,
    input  logic [AMT_W-1:0] need_opn,
    input  logic             need_buf,
    output logic             ok,
    output logic [15:0]      status
);
    import zone_admit_pkg::*;

    logic [CNT_W:0] act_sum;
    logic [CNT_W:0] opn_sum;
    logic           act_fail;
    logic           opn_fail;
    logic           buf_fail;

    always_comb begin
        act_sum  = {1'b0, act_used} + (CNT_W+1)'(need_act);
        opn_sum  = {1'b0, opn_used} + (CNT_W+1)'(need_opn);
        act_fail = (max_act != '0) && (act_sum > {1'b0, max_act});
        opn_fail = (max_opn != '0) && (opn_sum > {1'b0, max_opn});
        buf_fail = need_buf && (buf_free == '0);
        ok       = 1'b0;
        if (act_fail)      status = ST_ACT;
        else if (opn_fail) status = ST_OPN;
        else if (buf_fail) status = ST_BUF;
        else begin
            status = ST_OK;
            ok     = 1'b1;
        end
    end

endmodule

// File: rtl/zone_admit_ctr.sv
module zone_admit_ctr #(
    parameter int CNT_W     = 5,
    parameter int AMT_W     = 2,
    parameter bit ERR_ON_UP = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rst_val,
    input  logic [CNT_W-1:0] ceiling,
    input  logic [AMT_W-1:0] up_amt,
    input  logic [AMT_W-1:0] dn_amt,
    output logic [CNT_W-1:0] cnt_o,
    output logic             err_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   sum;
    logic             under;
    logic             over;

    always_comb begin
        sum   = {1'b0, cnt_q} + (CNT_W+1)'(up_amt);
        under = CNT_W'(dn_amt) > cnt_q;
        over  = (up_amt != '0) && (sum > {1'b0, ceiling});
        cnt_d = cnt_q;
        if (dn_amt != '0) begin
            if (!under) cnt_d = cnt_q - CNT_W'(dn_amt);
        end else if (up_amt != '0) begin
            cnt_d = over ? ceiling : sum[CNT_W-1:0];
        end
        err_o = ERR_ON_UP ? over : under;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= rst_val;
        else     cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/zone_admit.sv
module zone_admit #(
    parameter int ZONES = 16,
    parameter int AMT_W = 2,
    localparam int CNT_W = $clog2(ZONES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_max_active,
    input  logic [CNT_W-1:0] cfg_max_open,
    input  logic [CNT_W-1:0] cfg_num_buf,
    output logic             cfg_err,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AMT_W-1:0] req_act,
    input  logic [AMT_W-1:0] req_opn,
    input  logic             req_buf,
    input  logic             rel_valid,
    input  logic             rel_act,
    input  logic             rel_opn,
    input  logic             rel_buf,
    output logic             resp_valid,
    output logic [15:0]      resp_status,
    output logic [7:0]       resp_attr,
    output logic             err
);
    import zone_admit_pkg::*;

    localparam logic [CNT_W-1:0] ZONES_C = CNT_W'(ZONES);

    typedef struct packed {
        logic [CNT_W-1:0] max_act;
        logic [CNT_W-1:0] max_opn;
        logic [CNT_W-1:0] buf_total;
        logic             bad;
    } cfg_t;

    cfg_t  cfg_d, cfg_q;
    resp_t resp_d, resp_q;

    logic [CNT_W-1:0] pool_cnt  [NPOOL];
    logic [CNT_W-1:0] pool_rst  [NPOOL];
    logic [CNT_W-1:0] pool_ceil [NPOOL];
    logic [AMT_W-1:0] pool_up   [NPOOL];
    logic [AMT_W-1:0] pool_dn   [NPOOL];
    logic [NPOOL-1:0] pool_err;

    logic        accept;
    logic        chk_ok;
    logic [15:0] chk_status;

    always_comb begin
        cfg_d.max_act   = cfg_max_active;
        cfg_d.max_opn   = cfg_max_open;
        cfg_d.buf_total = (cfg_num_buf == '0) ? ZONES_C : cfg_num_buf;
        cfg_d.bad       = (cfg_max_active != '0) && (cfg_num_buf > cfg_max_active);
    end

    zone_admit_check #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_check (
        .act_used (pool_cnt[0]),
        .opn_used (pool_cnt[1]),
        .buf_free (pool_cnt[2]),
        .max_act  (cfg_q.max_act),
        .max_opn  (cfg_q.max_opn),
        .need_act (req_act),
        .need_opn (req_opn),
        .need_buf (req_buf),
        .ok       (chk_ok),
        .status   (chk_status)
    );

    always_comb begin
        req_ready = !rel_valid;
        accept    = req_valid && req_ready;

        pool_rst[0]  = '0;
        pool_rst[1]  = '0;
        pool_rst[2]  = cfg_d.buf_total;
        pool_ceil[0] = ZONES_C;
        pool_ceil[1] = ZONES_C;
        pool_ceil[2] = cfg_q.buf_total;

        pool_up[0] = '0;
        pool_up[1] = '0;
        pool_up[2] = AMT_W'(rel_valid && rel_buf);
        pool_dn[0] = AMT_W'(rel_valid && rel_act);
        pool_dn[1] = AMT_W'(rel_valid && rel_opn);
        pool_dn[2] = '0;
        if (accept && chk_ok) begin
            pool_up[0] = req_act;
            pool_up[1] = req_opn;
            pool_dn[2] = AMT_W'(req_buf);
        end

        resp_d.valid  = accept;
        resp_d.status = accept ? chk_status : ST_OK;
        resp_d.attr   = '0;
        resp_d.attr[ATTR_BUF] = accept && chk_ok && req_buf;
        resp_d.err    = rel_valid && (|pool_err);
    end

    for (genvar k = 0; k < NPOOL; k++) begin : g_pool
        zone_admit_ctr #(
            .CNT_W     (CNT_W),
            .AMT_W     (AMT_W),
            .ERR_ON_UP (k == 2)
        ) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .rst_val (pool_rst[k]),
            .ceiling (pool_ceil[k]),
            .up_amt  (pool_up[k]),
            .dn_amt  (pool_dn[k]),
            .cnt_o   (pool_cnt[k]),
            .err_o   (pool_err[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= cfg_d;
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign cfg_err     = cfg_q.bad;
    assign resp_valid  = resp_q.valid;
    assign resp_status = resp_q.status;
    assign resp_attr   = resp_q.attr;
    assign err         = resp_q.err;

endmodule

// File: rtl/zone_admit_chk.sv
module zone_admit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_buf,
    input logic        rel_valid,
    input logic        resp_valid,
    input logic [15:0] resp_status,
    input logic [7:0]  resp_attr,
    input logic        err
);
    // R13
    a_r13_resp_after_accept: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(req_valid && req_ready));

    // R12
    a_r12_release_first: assert property (@(posedge clk) disable iff (rst)
        rel_valid |-> !req_ready);

    // R6
    a_r6_code_legal: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_status == 16'h0000 || resp_status == 16'h41BD ||
                        resp_status == 16'h41BE || resp_status == 16'h41B7));

    // R7
    a_r7_refuse_attr: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_status != 16'h0000) |-> (resp_attr == 8'h00));

    // R7
    a_r7_buf_attr: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_attr[3]) |-> $past(req_buf));

    // R11
    a_r11_err_source: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(rel_valid));

endmodule

bind zone_admit zone_admit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_buf     (req_buf),
    .rel_valid   (rel_valid),
    .resp_valid  (resp_valid),
    .resp_status (resp_status),
    .resp_attr   (resp_attr),
    .err         (err)
);

// File: tb/zone_admit_bench.sv
module zone_admit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ZONES = 16;
    localparam int AMT_W = 2;
    localparam int CNT_W = $clog2(ZONES + 1);
    localparam int NVEC  = 16;

    // vector: [29] release, [28:27] act, [26:25] opn, [24] buf, [23:8] status, [7:0] attr
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 2'd1, 2'd1, 1'b1, 16'h0000, 8'h08},
        {1'b0, 2'd1, 2'd1, 1'b1, 16'h0000, 8'h08},
        {1'b0, 2'd1, 2'd0, 1'b1, 16'h41B7, 8'h00},
        {1'b0, 2'd1, 2'd1, 1'b0, 16'h41BE, 8'h00},
        {1'b0, 2'd3, 2'd1, 1'b1, 16'h41BD, 8'h00},
        {1'b0, 2'd2, 2'd0, 1'b0, 16'h0000, 8'h00},
        {1'b0, 2'd1, 2'd0, 1'b0, 16'h41BD, 8'h00},
        {1'b1, 2'd1, 2'd1, 1'b1, 16'h0000, 8'h00},
        {1'b0, 2'd1, 2'd1, 1'b1, 16'h0000, 8'h08},
        {1'b0, 2'd0, 2'd1, 1'b0, 16'h41BE, 8'h00},
        {1'b1, 2'd1, 2'd0, 1'b0, 16'h0000, 8'h00},
        {1'b0, 2'd1, 2'd0, 1'b1, 16'h41B7, 8'h00},
        {1'b1, 2'd0, 2'd0, 1'b1, 16'h0000, 8'h00},
        {1'b0, 2'd1, 2'd0, 1'b1, 16'h0000, 8'h08},
        {1'b1, 2'd0, 2'd0, 1'b1, 16'h0000, 8'h00},
        {1'b1, 2'd0, 2'd0, 1'b1, 16'h0000, 8'h00}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CNT_W-1:0] cfg_max_active = '0;
    logic [CNT_W-1:0] cfg_max_open = '0;
    logic [CNT_W-1:0] cfg_num_buf = '0;
    logic cfg_err;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AMT_W-1:0] req_act = '0;
    logic [AMT_W-1:0] req_opn = '0;
    logic req_buf = 1'b0;
    logic rel_valid = 1'b0;
    logic rel_act = 1'b0;
    logic rel_opn = 1'b0;
    logic rel_buf = 1'b0;
    logic resp_valid;
    logic [15:0] resp_status;
    logic [7:0] resp_attr;
    logic err;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] got_st;
    logic [7:0]  got_at;
    logic        got_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    zone_admit #(.ZONES(ZONES), .AMT_W(AMT_W)) u_zone_admit (
        .clk(clk), .rst(rst),
        .cfg_max_active(cfg_max_active), .cfg_max_open(cfg_max_open),
        .cfg_num_buf(cfg_num_buf), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_act(req_act), .req_opn(req_opn), .req_buf(req_buf),
        .rel_valid(rel_valid), .rel_act(rel_act), .rel_opn(rel_opn), .rel_buf(rel_buf),
        .resp_valid(resp_valid), .resp_status(resp_status),
        .resp_attr(resp_attr), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input int ma, input int mo, input int nb);
        @(negedge clk);
        rst = 1'b1;
        cfg_max_active = CNT_W'(ma);
        cfg_max_open = CNT_W'(mo);
        cfg_num_buf = CNT_W'(nb);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cfg_max_active = '0;
        cfg_max_open = '0;
        cfg_num_buf = '0;
    endtask

    task automatic do_req(input int a, input int o, input logic b);
        @(negedge clk);
        req_valid = 1'b1;
        req_act = AMT_W'(a);
        req_opn = AMT_W'(o);
        req_buf = b;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R13 resp_valid", 32'(resp_valid), 32'd1);
        got_st = resp_status;
        got_at = resp_attr;
    endtask

    task automatic do_rel(input logic a, input logic o, input logic b);
        @(negedge clk);
        rel_valid = 1'b1;
        rel_act = a;
        rel_opn = o;
        rel_buf = b;
        @(negedge clk);
        rel_valid = 1'b0;
        rel_act = 1'b0;
        rel_opn = 1'b0;
        rel_buf = 1'b0;
        got_err = err;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // Config A: max active 4, max open 2, two buffers
        do_reset(4, 2, 2);
        @(negedge clk);
        check("R1 resp_valid after reset", 32'(resp_valid), 32'd0);
        check("R1 err after reset", 32'(err), 32'd0);
        check("R1 req_ready after reset", 32'(req_ready), 32'd1);
        check("R10 cfg_err consistent", 32'(cfg_err), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][29]) begin
                do_rel(VEC[i][27], VEC[i][25], VEC[i][24]);
                check($sformatf("R8 vec %0d err", i), 32'(got_err), 32'd0);
            end else begin
                do_req(int'(VEC[i][28:27]), int'(VEC[i][26:25]), VEC[i][24]);
                check($sformatf("R3 R4 R5 R6 vec %0d status", i), 32'(got_st), 32'(VEC[i][23:8]));
                check($sformatf("R7 vec %0d attr", i), 32'(got_at), 32'(VEC[i][7:0]));
            end
        end

        // R11: pool is full (2 free); one more buffer release is unmatched
        do_rel(1'b0, 1'b0, 1'b1);
        check("R11 extra buffer release err", 32'(got_err), 32'd1);
        @(negedge clk);
        check("R11 err is one cycle", 32'(err), 32'd0);
        do_req(0, 0, 1'b1);
        check("R11 buffer grant 1", 32'(got_st), 32'h0000);
        do_req(0, 0, 1'b1);
        check("R11 buffer grant 2", 32'(got_st), 32'h0000);
        do_req(0, 0, 1'b1);
        check("R11 pool not above size", 32'(got_st), 32'h41B7);

        // R9 and R2: zero buffer count gives ZONES buffers, zero limits unenforced
        do_reset(0, 0, 0);
        for (int i = 0; i < ZONES; i++) begin
            do_req(1, 1, 1'b1);
            check($sformatf("R2 R9 grant %0d", i), 32'(got_st), 32'h0000);
        end
        do_req(1, 1, 1'b1);
        check("R9 pool exhausted", 32'(got_st), 32'h41B7);
        do_req(3, 3, 1'b0);
        check("R2 unlimited beyond zone count", 32'(got_st), 32'h0000);

        // R10: buffer count above non-zero active limit
        do_reset(1, 0, 2);
        @(negedge clk);
        check("R10 cfg_err set", 32'(cfg_err), 32'd1);

        // R11: underflow on active; R12: release beats request
        do_reset(1, 0, 1);
        @(negedge clk);
        check("R10 cfg_err clear", 32'(cfg_err), 32'd0);
        do_rel(1'b1, 1'b0, 1'b0);
        check("R11 unmatched active release err", 32'(got_err), 32'd1);
        do_rel(1'b0, 1'b1, 1'b0);
        check("R11 unmatched open release err", 32'(got_err), 32'd1);
        do_req(1, 0, 1'b0);
        check("R11 no underflow grant", 32'(got_st), 32'h0000);
        do_req(1, 0, 1'b0);
        check("R3 limit one reached", 32'(got_st), 32'h41BD);

        @(negedge clk);
        rel_valid = 1'b1;
        rel_act = 1'b1;
        req_valid = 1'b1;
        req_act = AMT_W'(1);
        req_opn = '0;
        req_buf = 1'b0;
        #1;
        check("R12 ready low during release", 32'(req_ready), 32'd0);
        @(negedge clk);
        rel_valid = 1'b0;
        rel_act = 1'b0;
        check("R12 no response during release", 32'(resp_valid), 32'd0);
        check("R8 matched release no err", 32'(err), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R12 request taken after release", 32'(resp_valid), 32'd1);
        check("R12 granted on freed slot", 32'(resp_status), 32'h0000);
        @(negedge clk);
        check("R13 single pulse", 32'(resp_valid), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule